// File: doc/BRIEF.md
# Timer Channel Count Register and Read-Latch Path

This block is the register layer of one timer channel. It sits between the bus decoder and the counting element. It takes byte writes and assembles them into a 16-bit count register. It also supplies the bytes that are read back, in one of three byte formats. Those bytes are either the live count, a frozen snapshot of it, or a frozen status byte.

The decoder hands the block these strobes, each one cycle long and each already qualified for this channel:
- a control-word write,
- a count-byte write,
- a read,
- a count-latch command,
- a status-latch command.

The counting element supplies the live count, the output pin level and a one-cycle pulse that marks the moment it takes the count register. In return the block offers the assembled count and a one-cycle pulse saying a complete new count is ready.

Snapshots are sticky. A second latch request made while one is still unread has no effect. A pending status snapshot is always served before a pending count snapshot. A "null" flag records whether the most recently written count has been taken by the counting element. The counting modes themselves live elsewhere; the mode bits are only stored here and reported.

Top module: `tmr_chan_regs`

## Requirements
- R1: After reset, count_reg is 0 and new_count_ready is 0. A read returns the low byte of live_count. Count-byte writes made before any control word leave count_reg at 0.
- R2: Control-word field bits:
  - wr_data[5:4] is the byte format.
  - wr_data[3:1] are the mode bits.
  - wr_data[0] is the decimal flag.
  
  A control word with a nonzero format does the following: stores bits 5:0, clears count_reg to 0, cancels any pending count or status snapshot, and returns both byte pointers to the low byte. A control-word strobe whose format field is 00 is a count-latch command and leaves the stored bits unchanged.
- R3: The format codes are 01 = low byte only, 10 = high byte only, 11 = low byte then high byte. In a single-byte format the byte that is not written stays 0 in count_reg, and reads return only the selected byte.
- R4: new_count_ready is high for one cycle, in the cycle after the final byte of the format is written. count_reg shows the new value in that same cycle. A first (low) byte in format 11 raises no pulse.
- R5: In format 11, successive count reads alternate low byte then high byte. Count writes and count reads of the channel may be interleaved, and neither changes the other's pointer.
- R6: A count latch freezes the value returned by reads. It stays frozen until the value has been read completely in the programmed format (one byte, or both bytes in format 11). Reads after that return the live count again.
- R7: A count latch while a snapshot is unread is ignored. A status latch while a status snapshot is unread is also ignored.
- R8: The status byte is {output level, null flag, stored control bits 5:0}. The output level is in bit 7 and the null flag in bit 6.
- R9: When both a status snapshot and a count snapshot are pending, the next read returns the status, whatever order they were taken in. The following one or two reads return the frozen count, and reads after that return the live count.
- R10: The null flag is set by a control word, or by the final byte of a count write. It is cleared by load_done. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cw_wr | input | 1 | Control-word write strobe for this channel (bits taken from wr_data) |
| cnt_wr | input | 1 | Count-byte write strobe |
| rd_strobe | input | 1 | Read strobe; consumes the byte shown on rd_data |
| cnt_latch_cmd | input | 1 | Count-latch command strobe |
| sts_latch_cmd | input | 1 | Status-latch command strobe |
| wr_data | input | 8 | Write data byte |
| live_count | input | 16 | Live value of the counting element |
| out_level | input | 1 | Current output pin level |
| load_done | input | 1 | Pulse: counting element has taken count_reg |
| rd_data | output | 8 | Byte the next read returns |
| count_reg | output | 16 | Assembled count register |
| new_count_ready | output | 1 | One-cycle pulse after a complete count write |

## Verification
The hardest situation to reach is a pair of pointers that sit out of phase. That happens when the read pointer sits on the high byte while a half-written count is pending on the write side, and it must be combined with snapshots that stay frozen while the live count keeps moving. The stimulus first parks the read pointer on the high byte with an odd number of reads. It then writes a lone low byte and reads again, which shows that each pointer advanced only on its own strobe. For the snapshot priority, a count latch is taken first and a status latch second, and live_count is changed after each. Only the order of returned bytes can then tell status, frozen count and live count apart.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  localparam int CTRL_W = 6;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_LOHI = 2'b11
  } fmt_e;

  function automatic fmt_e fmt_of(input logic [CTRL_W-1:0] bits);
    return fmt_e'(bits[5:4]);
  endfunction

endpackage

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
  import tmr_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_wr,
  input  logic [CTRL_W-1:0] cw_bits,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              cw_prog,
  output logic              cw_latch,
  output fmt_e              fmt
);

  logic [CTRL_W-1:0] ctrl_n;
  logic              ctrl_en;

  // A strobe with format 00 is a latch command, not a program.
  assign cw_prog  = cw_wr && (fmt_of(cw_bits) != FMT_NONE);
  assign cw_latch = cw_wr && (fmt_of(cw_bits) == FMT_NONE);
  assign ctrl_en  = cw_prog;
  assign fmt      = fmt_of(ctrl_q);

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_en) ctrl_n = cw_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_n;
  end

endmodule

// File: rtl/tmr_chan_wr.sv
module tmr_chan_wr
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_prog,
  input  fmt_e              fmt,
  input  logic              cnt_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              load_done,
  output logic [CNT_W-1:0]  cr_q,
  output logic              ready_q,
  output logic              null_q
);

  logic [CNT_W-1:0] cr_n;
  logic             wptr_q, wptr_n;
  logic             fin;
  logic             cr_en;
  logic             null_n;

  assign cr_en = cw_prog || cnt_wr;

  always_comb begin
    cr_n   = cr_q;
    wptr_n = wptr_q;
    fin    = 1'b0;
    if (cw_prog) begin
      cr_n   = '0;
      wptr_n = 1'b0;
    end else if (cnt_wr) begin
      unique case (fmt)
        FMT_LO: begin
          cr_n[0 +: BYTE_W] = wr_byte;
          fin = 1'b1;
        end
        FMT_HI: begin
          cr_n[BYTE_W +: BYTE_W] = wr_byte;
          fin = 1'b1;
        end
        FMT_LOHI: begin
          if (!wptr_q) begin
            cr_n[0 +: BYTE_W] = wr_byte;
            wptr_n = 1'b1;
          end else begin
            cr_n[BYTE_W +: BYTE_W] = wr_byte;
            wptr_n = 1'b0;
            fin = 1'b1;
          end
        end
        default: ;  // unprogrammed: write ignored
      endcase
    end
  end

  // Set has priority over the clear from the counting element.
  always_comb begin
    null_n = null_q;
    if (cw_prog || fin) null_n = 1'b1;
    else if (load_done) null_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q   <= '0;
      wptr_q <= 1'b0;
    end else if (cr_en) begin
      cr_q   <= cr_n;
      wptr_q <= wptr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      null_q  <= 1'b0;
    end else begin
      ready_q <= fin;
      null_q  <= null_n;
    end
  end

endmodule

// File: rtl/tmr_chan_rd.sv
module tmr_chan_rd
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_prog,
  input  fmt_e              fmt,
  input  logic              rd_strobe,
  input  logic              cnt_latch_req,
  input  logic              sts_latch_req,
  input  logic [CNT_W-1:0]  live_count,
  input  logic [BYTE_W-1:0] sts_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic              cnt_latched_q,
  output logic              sts_latched_q,
  output logic [CNT_W-1:0]  ol_q
);

  logic              cnt_latched_n, sts_latched_n;
  logic [CNT_W-1:0]  ol_n;
  logic [BYTE_W-1:0] sts_q, sts_n;
  logic              rptr_q, rptr_n;
  logic              ol_en, sts_en;
  logic              pick_hi;
  logic              last_byte;
  logic [CNT_W-1:0]  src;

  // Read source: frozen snapshot or the live value.
  assign src       = cnt_latched_q ? ol_q : live_count;
  assign pick_hi   = (fmt == FMT_HI) || ((fmt == FMT_LOHI) && rptr_q);
  assign last_byte = (fmt != FMT_LOHI) || rptr_q;
  assign rd_data   = sts_latched_q ? sts_q
                   : (pick_hi ? src[BYTE_W +: BYTE_W] : src[0 +: BYTE_W]);

  assign ol_en  = cnt_latch_req && !cnt_latched_q && !cw_prog;
  assign sts_en = sts_latch_req && !sts_latched_q && !cw_prog;

  always_comb begin
    cnt_latched_n = cnt_latched_q;
    sts_latched_n = sts_latched_q;
    rptr_n        = rptr_q;
    ol_n          = ol_q;
    sts_n         = sts_q;
    if (cw_prog) begin
      cnt_latched_n = 1'b0;
      sts_latched_n = 1'b0;
      rptr_n        = 1'b0;
    end else begin
      if (rd_strobe) begin
        if (sts_latched_q) begin
          sts_latched_n = 1'b0;
        end else begin
          if (fmt == FMT_LOHI) rptr_n = !rptr_q;
          if (last_byte) cnt_latched_n = 1'b0;
        end
      end
      if (ol_en) begin
        ol_n          = live_count;
        cnt_latched_n = 1'b1;
      end
      if (sts_en) begin
        sts_n         = sts_in;
        sts_latched_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_latched_q <= 1'b0;
      sts_latched_q <= 1'b0;
      rptr_q        <= 1'b0;
    end else begin
      cnt_latched_q <= cnt_latched_n;
      sts_latched_q <= sts_latched_n;
      rptr_q        <= rptr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ol_q <= '0;
    else if (ol_en) ol_q <= ol_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_n;
  end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_wr,
  input  logic              cnt_wr,
  input  logic              rd_strobe,
  input  logic              cnt_latch_cmd,
  input  logic              sts_latch_cmd,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              out_level,
  input  logic              load_done,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count_reg,
  output logic              new_count_ready
);

  logic [CTRL_W-1:0] ctrl_w;
  logic              cw_prog_w, cw_latch_w;
  fmt_e              fmt_w;
  logic              null_flag_w;
  logic              cnt_latched_w, sts_latched_w;
  logic [CNT_W-1:0]  ol_w;
  logic [BYTE_W-1:0] sts_byte_w;
  logic              cnt_latch_req_w;

  assign cnt_latch_req_w = cnt_latch_cmd || cw_latch_w;
  assign sts_byte_w      = {out_level, null_flag_w, ctrl_w};

  tmr_chan_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cw_wr    (cw_wr),
    .cw_bits  (wr_data[CTRL_W-1:0]),
    .ctrl_q   (ctrl_w),
    .cw_prog  (cw_prog_w),
    .cw_latch (cw_latch_w),
    .fmt      (fmt_w)
  );

  tmr_chan_wr #(.CNT_W(CNT_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw_prog   (cw_prog_w),
    .fmt       (fmt_w),
    .cnt_wr    (cnt_wr),
    .wr_byte   (wr_data),
    .load_done (load_done),
    .cr_q      (count_reg),
    .ready_q   (new_count_ready),
    .null_q    (null_flag_w)
  );

  tmr_chan_rd #(.CNT_W(CNT_W)) u_rd (
    .clk           (clk),
    .rst_n         (rst_n),
    .cw_prog       (cw_prog_w),
    .fmt           (fmt_w),
    .rd_strobe     (rd_strobe),
    .cnt_latch_req (cnt_latch_req_w),
    .sts_latch_req (sts_latch_cmd),
    .live_count    (live_count),
    .sts_in        (sts_byte_w),
    .rd_data       (rd_data),
    .cnt_latched_q (cnt_latched_w),
    .sts_latched_q (sts_latched_w),
    .ol_q          (ol_w)
  );

endmodule

// File: rtl/tmr_chan_regs_chk.sv
module tmr_chan_regs_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cw_prog,
  input logic             cnt_wr,
  input logic             sts_latch_cmd,
  input logic [CNT_W-1:0] count_reg,
  input logic             new_count_ready,
  input logic             null_flag,
  input logic             cnt_latched,
  input logic             sts_latched,
  input logic [CNT_W-1:0] ol
);

  // R2: programming clears the count register and cancels snapshots
  a_r2_prog_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cw_prog |=> (count_reg == '0) && !cnt_latched && !sts_latched);

  // R4: the ready pulse always follows a count-byte write
  a_r4_ready_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    new_count_ready |-> $past(cnt_wr));

  // R6: a held snapshot does not move while it stays held
  a_r6_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_latched && $past(cnt_latched)) |-> $stable(ol));

  // R7: a status snapshot only appears after a status-latch command
  a_r7_sts_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_latched) |-> $past(sts_latch_cmd));

  // R10: a completed count write leaves the null flag set
  a_r10_null_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    new_count_ready |-> null_flag);

endmodule

bind tmr_chan_regs tmr_chan_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cw_prog         (cw_prog_w),
  .cnt_wr          (cnt_wr),
  .sts_latch_cmd   (sts_latch_cmd),
  .count_reg       (count_reg),
  .new_count_ready (new_count_ready),
  .null_flag       (null_flag_w),
  .cnt_latched     (cnt_latched_w),
  .sts_latched     (sts_latched_w),
  .ol              (ol_w)
);

// File: tb/test_tmr_chan_regs.sv
`timescale 1ns/1ps
module test_tmr_chan_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cw_wr, cnt_wr, rd_strobe, cnt_latch_cmd, sts_latch_cmd;
  logic [7:0]  wr_data;
  logic [15:0] live_count;
  logic        out_level, load_done;
  logic [7:0]  rd_data;
  logic [15:0] count_reg;
  logic        new_count_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tmr_chan_regs i_tmr_chan_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .cw_wr           (cw_wr),
    .cnt_wr          (cnt_wr),
    .rd_strobe       (rd_strobe),
    .cnt_latch_cmd   (cnt_latch_cmd),
    .sts_latch_cmd   (sts_latch_cmd),
    .wr_data         (wr_data),
    .live_count      (live_count),
    .out_level       (out_level),
    .load_done       (load_done),
    .rd_data         (rd_data),
    .count_reg       (count_reg),
    .new_count_ready (new_count_ready)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_cw(input logic [7:0] d);
    @(negedge clk); cw_wr = 1'b1; wr_data = d;
    @(negedge clk); cw_wr = 1'b0;
  endtask

  task automatic put_cnt(input logic [7:0] d, output logic rdy);
    @(negedge clk); cnt_wr = 1'b1; wr_data = d;
    @(negedge clk); cnt_wr = 1'b0; rdy = new_count_ready;
  endtask

  task automatic get(output logic [7:0] v);
    @(negedge clk); #1 v = rd_data; rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic latch_cnt;
    @(negedge clk); cnt_latch_cmd = 1'b1;
    @(negedge clk); cnt_latch_cmd = 1'b0;
  endtask

  task automatic latch_sts;
    @(negedge clk); sts_latch_cmd = 1'b1;
    @(negedge clk); sts_latch_cmd = 1'b0;
  endtask

  task automatic pulse_load;
    @(negedge clk); load_done = 1'b1;
    @(negedge clk); load_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v; logic r;
    live_count = 16'hA55A;
    @(negedge clk);
    chk("R1 count_reg after reset", count_reg, 16'h0000);
    chk("R1 ready after reset", {15'd0, new_count_ready}, 16'h0000);
    get(v); chk("R1 unprogrammed read", {8'd0, v}, 16'h005A);
    put_cnt(8'h77, r);
    chk("R1 write before control word", count_reg, 16'h0000);
  endtask

  task automatic t_fmt_single;
    logic [7:0] v; logic r;
    put_cw(8'h14);                         // format 01
    put_cnt(8'h37, r);
    chk("R4 ready low-only", {15'd0, r}, 16'h0001);
    chk("R3 low-only count_reg", count_reg, 16'h0037);
    live_count = 16'h1234;
    get(v); chk("R3 low-only read", {8'd0, v}, 16'h0034);
    get(v); chk("R3 low-only reread", {8'd0, v}, 16'h0034);
    put_cw(8'h24);                         // format 10
    chk("R2 cw clears count_reg", count_reg, 16'h0000);
    put_cnt(8'h9A, r);
    chk("R3 high-only count_reg", count_reg, 16'h9A00);
    get(v); chk("R3 high-only read", {8'd0, v}, 16'h0012);
  endtask

  task automatic t_fmt_pair;
    logic [7:0] v; logic r;
    put_cw(8'h34);
    put_cnt(8'h11, r); chk("R4 no ready after first byte", {15'd0, r}, 16'h0000);
    put_cnt(8'h22, r); chk("R4 ready after second byte", {15'd0, r}, 16'h0001);
    chk("R4 count_reg pair", count_reg, 16'h2211);
    live_count = 16'hBEEF;
    get(v); chk("R5 read 1 low", {8'd0, v}, 16'h00EF);
    get(v); chk("R5 read 2 high", {8'd0, v}, 16'h00BE);
    get(v); chk("R5 read 3 low", {8'd0, v}, 16'h00EF);
    put_cnt(8'h33, r); chk("R5 interleaved low write", {15'd0, r}, 16'h0000);
    get(v); chk("R5 read ptr kept high", {8'd0, v}, 16'h00BE);
    put_cnt(8'h44, r); chk("R5 write ptr kept high", {15'd0, r}, 16'h0001);
    chk("R5 count_reg after interleave", count_reg, 16'h4433);
    get(v); chk("R5 read ptr back low", {8'd0, v}, 16'h00EF);
  endtask

  task automatic t_latch;
    logic [7:0] v;
    put_cw(8'h34);
    live_count = 16'h1357; latch_cnt(); live_count = 16'h2468;
    get(v); chk("R6 latched low", {8'd0, v}, 16'h0057);
    live_count = 16'h9999; latch_cnt();    // ignored: still unread
    get(v); chk("R7 second latch ignored", {8'd0, v}, 16'h0013);
    get(v); chk("R6 follows after full read", {8'd0, v}, 16'h0099);
    get(v);
    put_cw(8'h14);
    live_count = 16'h00AB; latch_cnt(); live_count = 16'h00CD;
    get(v); chk("R6 latched single byte", {8'd0, v}, 16'h00AB);
    get(v); chk("R6 released after one byte", {8'd0, v}, 16'h00CD);
  endtask

  task automatic t_cw_effects;
    logic [7:0] v;
    put_cw(8'h34);
    live_count = 16'h1111; latch_cnt();
    put_cw(8'h34);
    live_count = 16'h2222;
    get(v); chk("R2 cw cancels latch", {8'd0, v}, 16'h0022);
    get(v);
    live_count = 16'hCDEF; put_cw(8'h00); live_count = 16'h0000;
    get(v); chk("R2 format-00 cw latches low", {8'd0, v}, 16'h00EF);
    get(v); chk("R2 format-00 cw latches high", {8'd0, v}, 16'h00CD);
  endtask

  task automatic t_status;
    logic [7:0] v; logic r;
    out_level = 1'b1;
    put_cw(8'h37);
    latch_sts();
    pulse_load(); out_level = 1'b0;
    latch_sts();                           // ignored: status unread
    get(v); chk("R8 status layout", {8'd0, v}, 16'h00F7);
    chk("R7 status relatch ignored", {8'd0, v}, 16'h00F7);
    latch_sts();
    get(v); chk("R10 null cleared by load", {8'd0, v}, 16'h0037);
    put_cnt(8'h01, r);
    latch_sts();
    get(v); chk("R10 null after first byte", {8'd0, v}, 16'h0037);
    put_cnt(8'h02, r);
    latch_sts();
    get(v); chk("R10 null set by final byte", {8'd0, v}, 16'h0077);
    @(negedge clk); load_done = 1'b1; cnt_wr = 1'b1; wr_data = 8'h05;
    @(negedge clk); load_done = 1'b0; cnt_wr = 1'b0;
    put_cnt(8'h06, r);
    pulse_load();
    @(negedge clk); load_done = 1'b1; cw_wr = 1'b1; wr_data = 8'h37;
    @(negedge clk); load_done = 1'b0; cw_wr = 1'b0;
    latch_sts();
    get(v); chk("R10 set wins over load", {8'd0, v}, 16'h0077);
  endtask

  task automatic t_both;
    logic [7:0] v;
    out_level = 1'b1;
    put_cw(8'h34);
    pulse_load();
    live_count = 16'h0F0E; latch_cnt();
    live_count = 16'h5555; latch_sts();
    live_count = 16'h7777;
    get(v); chk("R9 status first", {8'd0, v}, 16'h00B4);
    get(v); chk("R9 frozen low", {8'd0, v}, 16'h000E);
    get(v); chk("R9 frozen high", {8'd0, v}, 16'h000F);
    get(v); chk("R9 then live", {8'd0, v}, 16'h0077);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cw_wr = 1'b0; cnt_wr = 1'b0; rd_strobe = 1'b0;
    cnt_latch_cmd = 1'b0; sts_latch_cmd = 1'b0;
    wr_data = 8'h00; live_count = 16'h0000;
    out_level = 1'b0; load_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fmt_single();
    t_fmt_pair();
    t_latch();
    t_cw_effects();
    t_status();
    t_both();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule